// File: doc/BRIEF.md
# Hot-Swap Timing and Fault Sequencer

This block is the digital sequencing core of a hot-swap power switch controller. It models the external timing capacitor as one saturating up/down counter that moves at four rates (charge 5 or 60 per tick, discharge 2 or 100 per tick) against two thresholds. The low threshold is derived as 2/13 of the high threshold. The same counter times three things: the insertion delay before the pass transistor is switched on, the overcurrent timeout, and the cool-off that follows a fault trip.

The sequencer reads a supply-good flag, a raw enable pin, a digitised overcurrent trip flag, a mode strap that selects auto-retry or latch-off, and an input that forces the timer to zero. It drives a gate-enable, a request for the strong gate discharge path, a fault flag and the timer value. The enable pin is glitch-filtered on its rising side only, and it is assumed to be already synchronous to `clk`. With default parameters (`HIGH_TH`=1300, so the low threshold is 200) a persistent fault in auto-retry mode gives 19 ticks on and 570 ticks off.

Top module: `hsw_sequencer`

## Requirements
- R1: While `uv_ok` is low, or the accepted enable is low, the block holds its idle state. In that state `gate_en`=0, `fault`=0 and `gate_pd`=1, and the timer falls by 100 per tick, saturating at 0. `gate_en` drops on the clock after `uv_ok` falls, and two clocks after `en_raw` falls.
- R2: `en_raw` is accepted only after it has been high on `FILT_CYCLES` consecutive clock edges. A shorter high pulse has no effect. A falling edge is accepted on the next edge.
- R3: An initial cycle starts only when `uv_ok` is high, the enable is accepted, `force_low` is low and the timer is below the low threshold. The first timer increment appears two clocks after acceptance.
- R4: In the initial cycle the timer rises by 5 per tick until it reaches at least `HIGH_TH`. It then falls by 100 per tick. `gate_en` rises on the same clock that the timer value reaches the low threshold or less.
- R5: While `gate_en`=1, an asserted `trip` raises the timer by 60 per tick. A cleared `trip` lowers it by 2 per tick. Neither case alters `gate_en` or `fault` until the high threshold is reached.
- R6: When the timer reaches at least `HIGH_TH` during a trip with the gate on, `gate_en` falls on that clock, and `fault` and `gate_pd` rise.
- R7: With `retry_mode`=1, after a fault trip the timer falls by 2 per tick. When it reaches the low threshold or less, `gate_en` is set again. Under a persistent trip at the defaults, the gate is on for 19 ticks and off for 570 ticks.
- R8: With `retry_mode`=0, after a fault trip the timer rises by 5 per tick. `gate_en` stays 0 and `fault` stays 1 whatever `trip` does.
- R9: A latched fault is cleared either by `force_low`, which returns the block to idle and restarts the initial cycle once released, or by `en_raw` going low and then being accepted high again.
- R10: While `force_low` is high, the timer reads 0 on the next clock in every state.
- R11: The timer saturates at 0 and at 2^`TMR_W`-1 and never wraps.
- R12: The timer changes only on every `PRESCALE`-th clock. All durations scale by `PRESCALE`: the retry pattern becomes 57 on and 1710 off clocks for `PRESCALE`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_ok | input | 1 | Supply is above the undervoltage limit |
| en_raw | input | 1 | Raw enable pin (synchronous) |
| trip | input | 1 | Overcurrent comparator output |
| retry_mode | input | 1 | 1 = auto-retry, 0 = latch-off |
| force_low | input | 1 | Forces the timer to zero and clears a latch |
| gate_en | output | 1 | Switch the pass transistor on |
| gate_pd | output | 1 | Request strong gate discharge |
| fault | output | 1 | Overcurrent fault active |
| timer_cnt | output | TMR_W | Emulated timer value |

## Verification
The hardest situation to reach is the steady auto-retry regime. In that regime the on time begins from the low threshold rather than from zero, and the on and off lengths depend on where the counter overshoots each threshold. The bench holds `trip` high through a first trip, which starts from zero, and then times a later on/off pair on both a prescale-1 and a prescale-3 instance. The saturated latch state is reached by leaving a latched instance charging long enough to hit full scale. The bench then checks that it ignores `trip` before it is cleared.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT_UP = 3'd1,
        ST_WAIT_DN = 3'd2,
        ST_RUN     = 3'd3,
        ST_COOL    = 3'd4,
        ST_LOCK    = 3'd5
    } hsw_state_e;

    localparam int STEP_W = 7;

    typedef struct packed {
        logic              rise;
        logic [STEP_W-1:0] step;
    } hsw_slew_t;

    localparam logic [STEP_W-1:0] STEP_SLOW_UP = 7'd5;
    localparam logic [STEP_W-1:0] STEP_FAST_UP = 7'd60;
    localparam logic [STEP_W-1:0] STEP_SLOW_DN = 7'd2;
    localparam logic [STEP_W-1:0] STEP_FAST_DN = 7'd100;

    function automatic int low_from_high(input int high);
        return (high * 2) / 13;
    endfunction

    function automatic hsw_slew_t slew_for(input hsw_state_e st, input logic trip);
        hsw_slew_t s;
        case (st)
            ST_WAIT_UP: s = '{rise: 1'b1, step: STEP_SLOW_UP};
            ST_WAIT_DN: s = '{rise: 1'b0, step: STEP_FAST_DN};
            ST_RUN:     s = trip ? '{rise: 1'b1, step: STEP_FAST_UP}
                                 : '{rise: 1'b0, step: STEP_SLOW_DN};
            ST_COOL:    s = '{rise: 1'b0, step: STEP_SLOW_DN};
            ST_LOCK:    s = '{rise: 1'b1, step: STEP_SLOW_UP};
            default:    s = '{rise: 1'b0, step: STEP_FAST_DN};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hsw_en_filter.sv
module hsw_en_filter #(
    parameter int FILT_CYCLES = 375
) (
    input  logic clk,
    input  logic rst,
    input  logic en_raw,
    output logic en_ok
);
    localparam int FW = $clog2(FILT_CYCLES + 1);
    localparam logic [FW-1:0] LAST = FW'(FILT_CYCLES - 1);

    logic [FW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            en_ok   <= 1'b0;
        end else if (!en_raw) begin
            run_cnt <= '0;
            en_ok   <= 1'b0;
        end else if (run_cnt == LAST) begin
            en_ok   <= 1'b1;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_fall_fast_R2: assert property (@(posedge clk) disable iff (rst)
        !en_raw |=> !en_ok);
    assert_rise_needs_pin_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(en_ok) |-> $past(en_raw));

endmodule

// File: rtl/hsw_slew_timer.sv
module hsw_slew_timer
    import hsw_pkg::*;
#(
    parameter int TMR_W    = 12,
    parameter int PRESCALE = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  hsw_slew_t        slew,
    input  logic             force_low,
    output logic [TMR_W-1:0] cnt,
    output logic [TMR_W-1:0] cnt_nxt
);
    localparam logic [TMR_W:0] FULL = {1'b0, {TMR_W{1'b1}}};

    logic          tick;
    logic [TMR_W:0] sum;
    logic [TMR_W-1:0] stepped;

    generate
        if (PRESCALE <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            logic [PW-1:0] div_cnt;
            always_ff @(posedge clk) begin
                if (rst)                              div_cnt <= '0;
                else if (div_cnt == PW'(PRESCALE - 1)) div_cnt <= '0;
                else                                  div_cnt <= div_cnt + 1'b1;
            end
            assign tick = (div_cnt == PW'(PRESCALE - 1));

            assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

    always_comb begin
        sum = {1'b0, cnt} + (TMR_W+1)'(slew.step);
        if (slew.rise)
            stepped = (sum > FULL) ? FULL[TMR_W-1:0] : sum[TMR_W-1:0];
        else
            stepped = (cnt < TMR_W'(slew.step)) ? '0 : cnt - TMR_W'(slew.step);

        if (force_low) cnt_nxt = '0;
        else if (tick) cnt_nxt = stepped;
        else           cnt_nxt = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    assert_no_wrap_up_R11: assert property (@(posedge clk) disable iff (rst)
        (slew.rise && !force_low) |=> cnt >= $past(cnt));
    assert_no_wrap_down_R11: assert property (@(posedge clk) disable iff (rst)
        (!slew.rise && !force_low) |=> cnt <= $past(cnt));
    assert_force_zero_R10: assert property (@(posedge clk) disable iff (rst)
        force_low |=> cnt == '0);
    assert_hold_between_ticks_R12: assert property (@(posedge clk) disable iff (rst)
        (!tick && !force_low) |=> $stable(cnt));

endmodule

// File: rtl/hsw_fsm.sv
module hsw_fsm
    import hsw_pkg::*;
#(
    parameter int               TMR_W = 12,
    parameter logic [TMR_W-1:0] HI    = 12'd1300,
    parameter logic [TMR_W-1:0] LO    = 12'd200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uv_ok,
    input  logic             en_ok,
    input  logic             trip,
    input  logic             retry_mode,
    input  logic             force_low,
    input  logic [TMR_W-1:0] cnt,
    input  logic [TMR_W-1:0] cnt_nxt,
    output hsw_state_e       state,
    output hsw_slew_t        slew
);
    hsw_state_e state_nxt;

    assign slew = slew_for(state, trip);

    always_comb begin
        state_nxt = state;
        if (!uv_ok || !en_ok) begin
            state_nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:    if (!force_low && cnt < LO) state_nxt = ST_WAIT_UP;
                ST_WAIT_UP: if (cnt_nxt >= HI)          state_nxt = ST_WAIT_DN;
                ST_WAIT_DN: if (cnt_nxt <= LO)          state_nxt = ST_RUN;
                ST_RUN:     if (trip && cnt_nxt >= HI)
                                state_nxt = retry_mode ? ST_COOL : ST_LOCK;
                ST_COOL:    if (cnt_nxt <= LO)          state_nxt = ST_RUN;
                ST_LOCK:    if (force_low)              state_nxt = ST_IDLE;
                default:                                state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    assert_gate_on_at_low_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) != ST_RUN) |-> cnt <= LO);
    assert_trip_off_at_high_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_RUN && state != ST_RUN && $past(uv_ok) && $past(en_ok))
        |-> cnt >= HI);
    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK && uv_ok && en_ok && !force_low) |=> state == ST_LOCK);
    assert_start_needs_low_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !(cnt < LO)) |=> state != ST_WAIT_UP);

endmodule

// File: rtl/hsw_sequencer.sv
module hsw_sequencer
    import hsw_pkg::*;
#(
    parameter int TMR_W       = 12,
    parameter int HIGH_TH     = 1300,
    parameter int PRESCALE    = 1,
    parameter int FILT_CYCLES = 375
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uv_ok,
    input  logic             en_raw,
    input  logic             trip,
    input  logic             retry_mode,
    input  logic             force_low,
    output logic             gate_en,
    output logic             gate_pd,
    output logic             fault,
    output logic [TMR_W-1:0] timer_cnt
);
    localparam logic [TMR_W-1:0] HI = TMR_W'(HIGH_TH);
    localparam logic [TMR_W-1:0] LO = TMR_W'(low_from_high(HIGH_TH));

    logic             en_ok;
    hsw_state_e       state;
    hsw_slew_t        slew;
    logic [TMR_W-1:0] cnt_nxt;

    hsw_en_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .en_raw (en_raw),
        .en_ok  (en_ok)
    );

    hsw_slew_timer #(.TMR_W(TMR_W), .PRESCALE(PRESCALE)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .slew      (slew),
        .force_low (force_low),
        .cnt       (timer_cnt),
        .cnt_nxt   (cnt_nxt)
    );

    hsw_fsm #(.TMR_W(TMR_W), .HI(HI), .LO(LO)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .uv_ok      (uv_ok),
        .en_ok      (en_ok),
        .trip       (trip),
        .retry_mode (retry_mode),
        .force_low  (force_low),
        .cnt        (timer_cnt),
        .cnt_nxt    (cnt_nxt),
        .state      (state),
        .slew       (slew)
    );

    assign gate_en = (state == ST_RUN);
    assign fault   = (state == ST_COOL) || (state == ST_LOCK);
    assign gate_pd = fault || (state == ST_IDLE);

    assert_uv_drops_gate_R1: assert property (@(posedge clk) disable iff (rst)
        !uv_ok |=> !gate_en);
    assert_en_drops_gate_R1: assert property (@(posedge clk) disable iff (rst)
        !en_raw |=> ##1 !gate_en);
    assert_fault_rise_gate_off_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $fell(gate_en) || !$past(gate_en));

endmodule

// File: tb/hsw_sequencer_tb_top.sv
module hsw_sequencer_tb_top;
    localparam int TW   = 12;
    localparam int HI   = 1300;
    localparam int LO   = (HI * 2) / 13;
    localparam int FILT = 4;
    localparam int FULL = (1 << TW) - 1;

    logic clk = 1'b0;
    logic rst, uv_ok, en_raw, trip, retry_mode, force_low;
    logic g1, pd1, f1, g3, pd3, f3;
    logic [TW-1:0] t1, t3;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hsw_sequencer #(.TMR_W(TW), .HIGH_TH(HI), .PRESCALE(1), .FILT_CYCLES(FILT)) dut_i (
        .clk(clk), .rst(rst), .uv_ok(uv_ok), .en_raw(en_raw), .trip(trip),
        .retry_mode(retry_mode), .force_low(force_low),
        .gate_en(g1), .gate_pd(pd1), .fault(f1), .timer_cnt(t1));

    hsw_sequencer #(.TMR_W(TW), .HIGH_TH(HI), .PRESCALE(3), .FILT_CYCLES(FILT)) dut_p3_i (
        .clk(clk), .rst(rst), .uv_ok(uv_ok), .en_raw(en_raw), .trip(trip),
        .retry_mode(retry_mode), .force_low(force_low),
        .gate_en(g3), .gate_pd(pd3), .fault(f3), .timer_cnt(t3));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic logic gate_of(input bit sel);
        return sel ? g3 : g1;
    endfunction

    task automatic measure_retry(input bit sel, output int on_c, output int off_c);
        on_c = 0;
        off_c = 0;
        while (gate_of(sel))  step(1);
        while (!gate_of(sel)) step(1);
        while (gate_of(sel))  begin on_c++;  step(1); end
        while (!gate_of(sel)) begin off_c++; step(1); end
    endtask

    task automatic wait_until_g1(input int limit);
        for (int i = 0; i < limit && !g1; i++) step(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int up_t, dn_t, lows, peak, on_t, off_t, first_off, on_c, off_c, mx;
        logic [TW-1:0] prev;
        up_t  = cdiv(HI, 5);
        dn_t  = cdiv(up_t * 5 - LO, 100);
        on_t  = cdiv(HI - LO, 60);
        peak  = LO + 60 * on_t;
        off_t = cdiv(peak - LO, 2);
        first_off = cdiv(cdiv(HI, 60) * 60 - LO, 2);

        rst = 1'b1; uv_ok = 1'b1; en_raw = 1'b0; trip = 1'b0;
        retry_mode = 1'b1; force_low = 1'b0;
        step(3);
        rst = 1'b0;
        step(2);
        // R1 idle state after reset
        chk(!g1 && !f1 && pd1, "R1 idle outputs", {g1, f1, pd1}, 1);
        chk(t1 == 0, "R1 idle timer", t1, 0);

        // R2 short enable pulse ignored
        en_raw = 1'b1; step(FILT - 1); en_raw = 1'b0;
        mx = 0;
        for (int i = 0; i < 10; i++) begin step(1); if (t1 > mx) mx = t1; end
        chk(mx == 0 && !g1, "R2 short pulse ignored", mx, 0);

        // R2/R3 acceptance latency
        en_raw = 1'b1;
        step(FILT + 1);
        chk(t1 == 0, "R2 no start before accept", t1, 0);
        step(1);
        chk(t1 == 5, "R3 first increment", t1, 5);

        // R4 initial cycle shape
        lows = 0; mx = 0;
        for (int i = 0; i < 2000 && !g1; i++) begin
            if (t1 > 0) lows++;
            if (t1 > mx) mx = t1;
            step(1);
        end
        chk(mx == up_t * 5, "R4 initial peak", mx, up_t * 5);
        chk(lows == up_t + dn_t - 1, "R4 initial duration", lows, up_t + dn_t - 1);
        chk(g1 && t1 == LO, "R4 gate on at low threshold", t1, LO);
        chk(!pd1 && !f1, "R4 no pulldown when on", pd1, 0);

        // R11 floor saturation
        step(LO / 2 + 10);
        chk(t1 == 0 && g1, "R11 floor at zero", t1, 0);

        // R5 transient trip
        trip = 1'b1; step(5);
        chk(t1 == 300, "R5 fast charge", t1, 300);
        trip = 1'b0; step(10);
        chk(t1 == 280, "R5 slow discharge", t1, 280);
        chk(g1 && !f1, "R5 gate kept", {g1, f1}, 2);
        step(160);

        // R6 persistent trip from zero
        trip = 1'b1;
        step(cdiv(HI, 60) - 1);
        chk(g1 && t1 == (cdiv(HI, 60) - 1) * 60, "R6 before trip-off", t1, (cdiv(HI, 60) - 1) * 60);
        step(1);
        chk(!g1 && f1 && pd1, "R6 trip-off outputs", {g1, f1, pd1}, 3);
        chk(t1 == cdiv(HI, 60) * 60, "R6 trip-off timer", t1, cdiv(HI, 60) * 60);
        off_c = 0;
        while (!g1 && off_c < 5000) begin off_c++; step(1); end
        chk(off_c == first_off, "R7 first cool-off", off_c, first_off);

        // R7 steady retry ratio
        measure_retry(1'b0, on_c, off_c);
        chk(on_c == on_t, "R7 retry on time", on_c, on_t);
        chk(off_c == off_t, "R7 retry off time", off_c, off_t);

        // R12 prescaled instance
        measure_retry(1'b1, on_c, off_c);
        chk(on_c == on_t * 3, "R12 prescaled on time", on_c, on_t * 3);
        chk(off_c == off_t * 3, "R12 prescaled off time", off_c, off_t * 3);

        // R8 latch-off mode
        trip = 1'b0; en_raw = 1'b0; step(60);
        retry_mode = 1'b0; trip = 1'b1; en_raw = 1'b1;
        for (int i = 0; i < 3000 && !f1; i++) step(1);
        chk(f1 && t1 == peak, "R8 latched at trip", t1, peak);
        step(cdiv(FULL - peak, 5) + 20);
        chk(t1 == FULL, "R11 full-scale saturation", t1, FULL);
        chk(!g1 && f1, "R8 latched gate off", {g1, f1}, 1);
        trip = 1'b0; step(20);
        chk(!g1 && f1 && t1 == FULL, "R8 trip clear ignored", t1, FULL);

        // R9/R10 clear by force_low
        force_low = 1'b1; step(1);
        chk(t1 == 0, "R10 forced zero", t1, 0);
        chk(!f1 && pd1, "R9 force clears latch", f1, 0);
        step(2);
        force_low = 1'b0; step(2);
        chk(t1 == 5, "R9 restart after force", t1, 5);

        // R9 clear by enable toggle
        wait_until_g1(3000);
        trip = 1'b1;
        for (int i = 0; i < 3000 && !f1; i++) step(1);
        chk(f1, "R9 latched again", f1, 1);
        trip = 1'b0; en_raw = 1'b0; step(2);
        chk(!f1 && pd1 && !g1, "R9 enable low clears", f1, 0);
        en_raw = 1'b1;
        wait_until_g1(3000);
        chk(g1 && !f1, "R9 restart after toggle", g1, 1);

        // R10 force while running
        step(LO / 2 + 10);
        trip = 1'b1; step(10); trip = 1'b0;
        chk(t1 == 600, "R5 charge from zero", t1, 600);
        force_low = 1'b1; step(1); force_low = 1'b0;
        chk(t1 == 0 && g1, "R10 force keeps gate", t1, 0);

        // R1 supply drop
        trip = 1'b1; step(10);
        uv_ok = 1'b0; trip = 1'b0; step(1);
        chk(!g1 && pd1, "R1 uv drop gate off", g1, 0);
        chk(t1 == 598, "R1 last run step", t1, 598);
        step(1);
        prev = t1;
        chk(prev == 498, "R1 fast discharge", prev, 498);

        // R3 no start while supply low
        step(30);
        chk(t1 == 0 && !g1, "R3 blocked by supply", t1, 0);
        uv_ok = 1'b1; step(2);
        chk(t1 == 5, "R3 start when supply good", t1, 5);

        // R1 enable drop
        wait_until_g1(3000);
        en_raw = 1'b0; step(1);
        chk(g1, "R1 gate one cycle after enable low", g1, 1);
        step(1);
        chk(!g1 && pd1, "R1 enable low gate off", g1, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule